// File: doc/BRIEF.md
# Address-Value Delta Load Predictor

This block is a small table, searched by load PC, that learns for each pointer-chasing load the gap between the address the load reads and the value it gets back. A training port reports every completed load with its PC, effective address and returned data. When the gap for a load PC keeps repeating, the table gains confidence in it.

A lookup port is used by a core running ahead of a long-latency miss. When such a load misses and the core is in runahead mode, the block supplies a guessed data value: the lookup's own effective address minus the learned gap. Dependent loads can then compute their addresses and issue their own misses early. Loads whose returned value lies far from their own address are not treated as pointer loads and are never stored.

Top module: `avd_predictor`

## Requirements
- R1: After reset, no lookup produces a prediction until some load PC has been trained again.
- R2: The stored delta is `tr_ea - tr_data`, taken modulo 2^W as a two's complement value, so it may be negative. The predicted value is `lk_ea - delta`, also modulo 2^W.
- R3: Each entry has a 2-bit confidence counter. Allocation sets it to 0, and each training with an equal delta raises it, saturating at 3. A prediction needs the counter at 3, so the fourth consistent training of a PC is the first that enables it.
- R4: A training with a delta different from the stored one replaces the delta and clears confidence to 0.
- R5: `pred_valid` is high only when `lk_miss` and `lk_runahead` are both high and the looked-up PC hits an entry with full confidence.
- R6: A training whose delta has magnitude at or above `DELTA_BOUND` (default 65536) is ignored. It allocates nothing, changes no entry and does not affect replacement order. Magnitudes of `DELTA_BOUND-1` in either sign are accepted.
- R7: The table holds `ENTRIES` (default 16) independent PCs in any combination, fully associatively. An entry is only lost to reset or replacement.
- R8: A training whose PC misses allocates the lowest-numbered empty entry. If there is none, it takes the entry least recently touched by an accepted training. Lookups do not change replacement order.
- R9: A lookup in the same cycle as a training to the same PC sees the entry as it stood before that training. The update is visible from the next cycle.
- R10: The synchronous active-high reset clears all valid bits and confidence counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tr_valid | input | 1 | Training event present |
| tr_pc | input | PC_W | PC of the trained load |
| tr_ea | input | W | Effective address of the trained load |
| tr_data | input | W | Data returned to the trained load |
| lk_pc | input | PC_W | PC of the load being looked up |
| lk_ea | input | W | Effective address of the looked-up load |
| lk_miss | input | 1 | Looked-up load has a long-latency miss |
| lk_runahead | input | 1 | Core is in runahead mode |
| pred_valid | output | 1 | A predicted value is offered |
| pred_value | output | W | Predicted load data |

## Verification
The hardest state to reach is a full table in which the next allocation must evict exactly the least recently trained PC, while out-of-bound trainings and same-cycle lookups interleave with it. The stimulus draws trainings from a pool of 24 PCs, more than the table holds. Each PC has a mostly stable delta, with occasional changed or oversized deltas, so entries churn through eviction, retraining and saturation. A bench reference model with its own age order predicts every cycle's output. Directed sequences fill all 16 entries and then force one eviction. They also place a lookup in the same cycle as a retraining of the same PC, and probe the bound at exactly 65535 and 65536.

// File: rtl/avd_pkg.sv
package avd_pkg;
   typedef enum logic [2:0] {
      ACT_NONE,
      ACT_SKIP,
      ACT_ALLOC,
      ACT_REINFORCE,
      ACT_RETRAIN
   } train_act_e;
endpackage

// File: rtl/avd_delta_check.sv
module avd_delta_check #(
   parameter int          W           = 32,
   parameter int unsigned DELTA_BOUND = 65536
) (
   input  logic [W-1:0] ea,
   input  logic [W-1:0] data,
   output logic [W-1:0] delta,
   output logic         in_range
);
   localparam logic [W-1:0] BOUND_V = W'(DELTA_BOUND);
   logic [W-1:0] mag;

   always_comb begin
      delta    = ea - data;
      mag      = delta[W-1] ? (~delta + W'(1)) : delta;
      in_range = (mag < BOUND_V) && !(delta[W-1] && mag[W-1]);
   end
endmodule

// File: rtl/avd_cam.sv
module avd_cam #(
   parameter int PC_W    = 32,
   parameter int ENTRIES = 16,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [PC_W-1:0]   key,
   input  logic [PC_W-1:0]   tags [ENTRIES],
   input  logic [ENTRIES-1:0] valid,
   output logic              hit,
   output logic [IDX_W-1:0]  hit_idx
);
   logic [ENTRIES-1:0] hit_vec;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign hit_vec[e] = valid[e] && (tags[e] == key);
   end

   always_comb begin
      hit_idx = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (hit_vec[e]) hit_idx = IDX_W'(e);
      end
   end
   assign hit = |hit_vec;

   // R7
   unique_tag_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(hit_vec));
endmodule

// File: rtl/avd_lru.sv
module avd_lru #(
   parameter int ENTRIES = 16,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               touch,
   input  logic [IDX_W-1:0]   touch_idx,
   input  logic [ENTRIES-1:0] valid,
   output logic [IDX_W-1:0]   victim
);
   localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);
   logic [IDX_W-1:0] age_q [ENTRIES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int e = 0; e < ENTRIES; e++) age_q[e] <= IDX_W'(e);
      end else if (touch) begin
         for (int e = 0; e < ENTRIES; e++) begin
            if (IDX_W'(e) == touch_idx)          age_q[e] <= '0;
            else if (age_q[e] < age_q[touch_idx]) age_q[e] <= age_q[e] + IDX_W'(1);
         end
      end
   end

   always_comb begin
      logic found;
      found  = 1'b0;
      victim = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (!found && !valid[e]) begin
            victim = IDX_W'(e);
            found  = 1'b1;
         end
      end
      if (!found) begin
         for (int e = 0; e < ENTRIES; e++) begin
            if (age_q[e] == OLDEST) victim = IDX_W'(e);
         end
      end
   end

   // R8
   touch_young_chk: assert property (@(posedge clk) disable iff (rst)
      touch |=> age_q[$past(touch_idx)] == '0);
   // R8
   empty_first_chk: assert property (@(posedge clk) disable iff (rst)
      !(&valid) |-> !valid[victim]);
endmodule

// File: rtl/avd_predictor.sv
module avd_predictor
   import avd_pkg::*;
#(
   parameter int          PC_W        = 32,
   parameter int          W           = 32,
   parameter int          ENTRIES     = 16,
   parameter int          CONF_W      = 2,
   parameter int unsigned DELTA_BOUND = 65536
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            tr_valid,
   input  logic [PC_W-1:0] tr_pc,
   input  logic [W-1:0]    tr_ea,
   input  logic [W-1:0]    tr_data,
   input  logic [PC_W-1:0] lk_pc,
   input  logic [W-1:0]    lk_ea,
   input  logic            lk_miss,
   input  logic            lk_runahead,
   output logic            pred_valid,
   output logic [W-1:0]    pred_value
);
   localparam int IDX_W = $clog2(ENTRIES);
   localparam logic [CONF_W-1:0] CONF_MAX = {CONF_W{1'b1}};

   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("ENTRIES must be a power of two of at least 2");
   end
   if (CONF_W < 1) begin : g_bad_conf
      $error("CONF_W must be at least 1");
   end
   if (DELTA_BOUND == 0 || (W <= 32 && 64'(DELTA_BOUND) >= (64'(1) << (W - 1)))) begin : g_bad_bound
      $error("DELTA_BOUND must be nonzero and below 2**(W-1)");
   end

   logic [PC_W-1:0]    tag_q  [ENTRIES];
   logic [W-1:0]       dlt_q  [ENTRIES];
   logic [CONF_W-1:0]  conf_q [ENTRIES];
   logic [ENTRIES-1:0] vld_q;
   logic [ENTRIES*CONF_W-1:0] conf_flat;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_flat
      assign conf_flat[e*CONF_W +: CONF_W] = conf_q[e];
   end

   // training side
   logic [W-1:0]     t_delta;
   logic             t_ok, t_hit;
   logic [IDX_W-1:0] t_idx, victim, wr_idx;
   train_act_e       act;
   logic             touch;

   avd_delta_check #(.W(W), .DELTA_BOUND(DELTA_BOUND)) u_dchk (
      .ea(tr_ea), .data(tr_data), .delta(t_delta), .in_range(t_ok));

   avd_cam #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_tcam (
      .clk(clk), .rst(rst), .key(tr_pc), .tags(tag_q), .valid(vld_q),
      .hit(t_hit), .hit_idx(t_idx));

   avd_lru #(.ENTRIES(ENTRIES)) u_lru (
      .clk(clk), .rst(rst), .touch(touch), .touch_idx(wr_idx),
      .valid(vld_q), .victim(victim));

   always_comb begin
      act = ACT_NONE;
      if (tr_valid) begin
         if (!t_ok)                      act = ACT_SKIP;
         else if (!t_hit)                act = ACT_ALLOC;
         else if (dlt_q[t_idx] == t_delta) act = ACT_REINFORCE;
         else                            act = ACT_RETRAIN;
      end
   end

   assign wr_idx = t_hit ? t_idx : victim;
   assign touch  = (act == ACT_ALLOC) || (act == ACT_REINFORCE) || (act == ACT_RETRAIN);

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q <= '0;
         for (int e = 0; e < ENTRIES; e++) conf_q[e] <= '0;
      end else if (touch) begin
         for (int e = 0; e < ENTRIES; e++) begin
            if (IDX_W'(e) == wr_idx) begin
               case (act)
                  ACT_ALLOC: begin
                     vld_q[e]  <= 1'b1;
                     tag_q[e]  <= tr_pc;
                     dlt_q[e]  <= t_delta;
                     conf_q[e] <= '0;
                  end
                  ACT_REINFORCE: begin
                     if (conf_q[e] != CONF_MAX) conf_q[e] <= conf_q[e] + CONF_W'(1);
                  end
                  ACT_RETRAIN: begin
                     dlt_q[e]  <= t_delta;
                     conf_q[e] <= '0;
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   // lookup side: reads registered state, so same-cycle training is not seen
   logic             l_hit, l_conf_full;
   logic [IDX_W-1:0] l_idx;

   avd_cam #(.PC_W(PC_W), .ENTRIES(ENTRIES)) u_lcam (
      .clk(clk), .rst(rst), .key(lk_pc), .tags(tag_q), .valid(vld_q),
      .hit(l_hit), .hit_idx(l_idx));

   assign l_conf_full = (conf_q[l_idx] == CONF_MAX);
   assign pred_valid  = lk_miss && lk_runahead && l_hit && l_conf_full;
   assign pred_value  = lk_ea - dlt_q[l_idx];

   // R5
   pred_gate_chk: assert property (@(posedge clk) disable iff (rst)
      pred_valid |-> (lk_miss && lk_runahead));
   // R6
   skip_still_chk: assert property (@(posedge clk) disable iff (rst)
      (act == ACT_SKIP) |=> ($stable(vld_q) && $stable(conf_flat)));
   // R7
   vld_keep_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(vld_q) >= $past($countones(vld_q)));
   // R4
   retrain_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (act == ACT_RETRAIN) |=> (conf_q[$past(wr_idx)] == '0));
   // R8
   alloc_set_chk: assert property (@(posedge clk) disable iff (rst)
      (act == ACT_ALLOC) |=> vld_q[$past(wr_idx)]);
endmodule

// File: tb/avd_predictor_test.sv
`timescale 1ns/1ps
module avd_predictor_test;
   localparam int N = 16;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        tr_valid = 1'b0;
   logic [31:0] tr_pc = '0, tr_ea = '0, tr_data = '0;
   logic [31:0] lk_pc = '0, lk_ea = '0;
   logic        lk_miss = 1'b0, lk_runahead = 1'b0;
   logic        pred_valid;
   logic [31:0] pred_value;

   int vectors = 0;
   int errors  = 0;

   always #4 clk = ~clk;

   avd_predictor uut (
      .clk(clk), .rst(rst), .tr_valid(tr_valid), .tr_pc(tr_pc), .tr_ea(tr_ea),
      .tr_data(tr_data), .lk_pc(lk_pc), .lk_ea(lk_ea), .lk_miss(lk_miss),
      .lk_runahead(lk_runahead), .pred_valid(pred_valid), .pred_value(pred_value));

   // reference model
   bit        m_vld  [N];
   bit [31:0] m_pc   [N];
   bit [31:0] m_dlt  [N];
   int        m_conf [N];
   int        m_age  [N];

   function automatic void m_reset();
      for (int e = 0; e < N; e++) begin
         m_vld[e] = 0; m_conf[e] = 0; m_age[e] = e;
      end
   endfunction

   function automatic int m_find(bit [31:0] pc);
      for (int e = 0; e < N; e++) if (m_vld[e] && m_pc[e] == pc) return e;
      return -1;
   endfunction

   function automatic bit in_bound(bit [31:0] d);
      bit [31:0] mag = d[31] ? (~d + 32'd1) : d;
      return (mag < 32'd65536) && !(d[31] && mag[31]);
   endfunction

   function automatic void m_train(bit [31:0] pc, bit [31:0] ea, bit [31:0] dat);
      bit [31:0] d = ea - dat;
      int i;
      if (!in_bound(d)) return;
      i = m_find(pc);
      if (i < 0) begin
         for (int e = N - 1; e >= 0; e--) if (!m_vld[e]) i = e;
         if (i < 0) for (int e = 0; e < N; e++) if (m_age[e] == N - 1) i = e;
         m_vld[i] = 1; m_pc[i] = pc; m_dlt[i] = d; m_conf[i] = 0;
      end else if (m_dlt[i] == d) begin
         if (m_conf[i] < 3) m_conf[i]++;
      end else begin
         m_dlt[i] = d; m_conf[i] = 0;
      end
      for (int e = 0; e < N; e++) if (e != i && m_age[e] < m_age[i]) m_age[e]++;
      m_age[i] = 0;
   endfunction

   task automatic step(bit tv, bit [31:0] tpc, bit [31:0] tea, bit [31:0] tdat,
                       bit [31:0] lpc, bit [31:0] lea, bit miss, bit ra, string req);
      int  i;
      bit  ev;
      bit [31:0] exv;
      @(negedge clk);
      tr_valid = tv; tr_pc = tpc; tr_ea = tea; tr_data = tdat;
      lk_pc = lpc; lk_ea = lea; lk_miss = miss; lk_runahead = ra;
      #1;
      i   = m_find(lpc);
      ev  = miss && ra && (i >= 0) && (m_conf[i] == 3);
      exv = (i >= 0) ? lea - m_dlt[i] : 32'd0;
      vectors++;
      if (pred_valid !== ev) begin
         errors++;
         $display("FAIL %s: pred_valid=%b expected %b (pc=%h)", req, pred_valid, ev, lpc);
      end else if (ev && pred_value !== exv) begin
         errors++;
         $display("FAIL %s: pred_value=%h expected %h (pc=%h)", req, pred_value, exv, lpc);
      end
      @(posedge clk);
      if (tv) m_train(tpc, tea, tdat);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; tr_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      m_reset();
   endtask

   // train pc with delta d, lookup same pc
   task automatic tr_look(bit [31:0] pc, bit [31:0] d, string req);
      step(1, pc, 32'h4000_0000, 32'h4000_0000 - d, pc, 32'h5000_0000, 1, 1, req);
   endtask

   task automatic look(bit [31:0] pc, bit miss, bit ra, string req);
      step(0, 0, 0, 0, pc, 32'h1234_5678, miss, ra, req);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: run still going, expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      m_reset();
      do_reset();

      // R1 / R10: empty after reset
      look(32'h100, 1, 1, "R1");
      look(32'h0, 1, 1, "R10");

      // R3 / R2: four consistent trainings needed; lookups in the same cycle (R9)
      for (int k = 0; k < 4; k++) tr_look(32'h100, 32'h40, "R3");
      look(32'h100, 1, 1, "R2");
      // R5: gating
      look(32'h100, 0, 1, "R5");
      look(32'h100, 1, 0, "R5");
      look(32'h100, 0, 0, "R5");
      // R2: negative delta
      for (int k = 0; k < 5; k++) tr_look(32'h200, -32'sd256, "R2");
      // R9: retrain in the same cycle as a lookup sees old contents
      step(1, 32'h100, 32'h9000, 32'h9000 - 32'h80, 32'h100, 32'hABC0, 1, 1, "R9");
      // R4: new delta cleared confidence
      look(32'h100, 1, 1, "R4");
      for (int k = 0; k < 4; k++) tr_look(32'h100, 32'h80, "R4");
      // R6: out-of-bound training leaves the entry alone
      tr_look(32'h100, 32'd65536, "R6");
      look(32'h100, 1, 1, "R6");
      tr_look(32'h300, -32'sd65536, "R6");
      look(32'h300, 1, 1, "R6");
      for (int k = 0; k < 4; k++) tr_look(32'h300, 32'd65535, "R6");
      for (int k = 0; k < 4; k++) tr_look(32'h301, -32'sd65535, "R6");
      tr_look(32'h302, 32'h8000_0000, "R6");

      // R7 / R8: fill table, then evict the least recently trained
      do_reset();
      for (int k = 0; k < 4; k++)
         for (int p = 0; p < N; p++) tr_look(32'h1000 + p, 32'h10 * p, "R7");
      for (int p = 0; p < N; p++) look(32'h1000 + p, 1, 1, "R7");
      tr_look(32'h1000, 32'h0, "R8");
      tr_look(32'h2000, 32'h8, "R8");
      look(32'h1001, 1, 1, "R8");
      look(32'h1000, 1, 1, "R8");
      for (int p = 2; p < N; p++) look(32'h1000 + p, 1, 1, "R8");

      // R10: mid-run reset
      do_reset();
      look(32'h1005, 1, 1, "R10");

      // random mix over a pool larger than the table
      begin
         bit [31:0] base [24];
         for (int p = 0; p < 24; p++)
            base[p] = (p % 7 == 6) ? 32'h0002_0000 : (($urandom % 2048) - 1024);
         for (int n = 0; n < 4000; n++) begin
            int tp = $urandom % 24;
            int lp = $urandom % 24;
            bit [31:0] d = base[tp];
            bit [31:0] ea = $urandom;
            int r = $urandom % 20;
            if (r == 0) d = $urandom % 4096;
            else if (r == 1) d = $urandom;
            if (r == 2) d = 32'd65536 - ($urandom % 2);
            step(($urandom % 10) < 7, 32'h8000 + tp * 4, ea, ea - d,
                 32'h8000 + lp * 4, $urandom, ($urandom % 4) != 0, ($urandom % 4) != 0,
                 "R8");
            if (n == 2000) do_reset();
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule